// File: doc/BRIEF.md
# Daisy-Chain Serial Converter Host Sequencer

This block is the host side of a chain of serial sampling converters that share one convert strobe, one chip-select and one data clock, with each device's data output wired to the tag input of the device nearer the host. A single start request makes the block command a conversion, wait for the converters to finish, then clock the whole chain out through one serial input and present the collected samples as parallel words with a one-cycle valid strobe.

The conversion is commanded by pulling chip-select and read/convert low together for a programmable number of cycles. Both lines are then released high well before the converters' busy line rises, so that no second conversion starts by accident. Once busy has gone low and come back high, chip-select is dropped with read/convert held high, which starts the readout. The block then generates CHAIN×WBITS data clock pulses. Each device shifts out its own bits first and then forwards what arrives on its tag input, delayed by one word, so the host receives the words in chain order. The chain length, the word width, the read/convert low width and the data clock half-period are parameters.

Top module: `chain_adc_host`

## Requirements
- R1: After reset, rc_o = 1, cs_n_o = 1, dclk_o = 0, valid_o = 0 and active_o = 0.
- R2: A start_i pulse seen in idle drives rc_o and cs_n_o low together for exactly RC_LOW clock cycles. rc_o is never low while cs_n_o is high.
- R3: rc_o and cs_n_o are both high in the cycle in which busy_i rises after a conversion command.
- R4: The readout begins with cs_n_o falling while rc_o is high. It happens only after busy_i has been seen low and then high again. In one readout dclk_o gives exactly CHAIN×WBITS rising edges, each high phase lasts DCLK_HALF cycles, and dclk_o is low whenever cs_n_o is high.
- R5: sdata_i is sampled at the end of each dclk_o high phase, most significant bit first. Word k (words_o bits k×WBITS upward) is the k-th WBITS-bit group received, and group 0 comes from the device nearest the host.
- R6: valid_o is high for exactly one cycle per readout, in the cycle after the last bit is sampled. words_o holds its value until the next valid_o.
- R7: start_i is ignored while active_o is high. No further conversion command is issued, and the block returns to idle after its single valid_o.
- R8: In the valid_o cycle cs_n_o is high and dclk_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one convert-and-read transaction |
| busy_i | input | 1 | Converter busy line, low while converting |
| sdata_i | input | 1 | Serial data from the nearest device in the chain |
| rc_o | output | 1 | Read/convert control to all devices |
| cs_n_o | output | 1 | Chip-select to all devices, active low |
| dclk_o | output | 1 | Data clock driven to all devices |
| words_o | output | CHAIN×WBITS | Collected words, word k at bits k×WBITS upward |
| valid_o | output | 1 | One-cycle strobe marking a new words_o |
| active_o | output | 1 | High from accepted start until the valid cycle |

## Verification
Suppose the sequencer is in the wrong state or the bit counter is off by one. The first then shows within a few cycles as a wrong read/convert width or a chip-select edge at the wrong moment. The second shows at the end of the readout as a wrong number of data clock edges and every word shifted by one bit. Any slip in the group order shows up as swapped words the moment valid rises. The bench drives a chain of behavioural converter models with distinct values per device, so both bit and word misplacement are visible.

// File: rtl/chain_pkg.sv
package chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_GAP,
    ST_WAITHI,
    ST_READ,
    ST_DONE
  } seq_state_t;

  // Offset in the receive shift register of the group that arrived k-th.
  function automatic int group_base(input int k, input int n, input int w);
    return (n - 1 - k) * w;
  endfunction

endpackage

// File: rtl/chain_seq.sv
module chain_seq
  import chain_pkg::*;
#(
  parameter int RC_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic last_bit,
  output logic rc_o,
  output logic cs_n_o,
  output logic run_o,
  output logic active_o,
  output logic valid_o
);
  localparam int CW = $clog2(RC_LOW + 1);
  localparam logic [CW-1:0] CLAST = CW'(RC_LOW - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;

  // named events for assertions
  wire in_conv = (state == ST_CONV);
  wire in_read = (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (start_i) begin state <= ST_CONV; cnt <= '0; end
        ST_CONV:   if (cnt == CLAST) state <= ST_GAP; else cnt <= cnt + 1'b1;
        ST_GAP:    if (!busy_i) state <= ST_WAITHI;
        ST_WAITHI: if (busy_i) state <= ST_READ;
        ST_READ:   if (last_bit) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign rc_o     = !in_conv;
  assign cs_n_o   = !(in_conv || in_read);
  assign run_o    = in_read;
  assign active_o = (state != ST_IDLE);
  assign valid_o  = (state == ST_DONE);

  assert_rc_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_o |-> !cs_n_o);
  assert_rc_high_at_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> rc_o);
  assert_cs_high_at_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> cs_n_o);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !in_conv) |=> !in_conv);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/chain_dclk.sv
module chain_dclk #(
  parameter int DCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk_o,
  output logic tick_o
);
  localparam int HW = $clog2(DCLK_HALF + 1);
  localparam logic [HW-1:0] HLAST = HW'(DCLK_HALF - 1);

  logic [HW-1:0] hcnt;
  wire half_end = (hcnt == HLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      dclk_o <= 1'b0;
    end else if (!run) begin
      hcnt   <= '0;
      dclk_o <= 1'b0;
    end else if (half_end) begin
      hcnt   <= '0;
      dclk_o <= !dclk_o;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // sample point: last cycle of a high phase
  assign tick_o = run && dclk_o && half_end;

  assert_dclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !dclk_o);
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/chain_collect.sv
module chain_collect #(
  parameter int TOTAL = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             sdata,
  output logic             last_o,
  output logic [TOTAL-1:0] bits_o
);
  localparam int BW = $clog2(TOTAL + 1);
  localparam logic [BW-1:0] BLAST = BW'(TOTAL - 1);

  logic [TOTAL-1:0] sr;
  logic [BW-1:0]    bcnt;
  wire  [TOTAL-1:0] sr_next = {sr[TOTAL-2:0], sdata};

  assign last_o = tick && (bcnt == BLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      bcnt   <= '0;
      bits_o <= '0;
    end else begin
      if (!run) bcnt <= '0;
      else if (tick) begin
        sr   <= sr_next;
        bcnt <= bcnt + 1'b1;
      end
      if (last_o) bits_o <= sr_next;
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(TOTAL));
  assert_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last_o) |-> $stable(bits_o));

endmodule

// File: rtl/chain_adc_host.sv
module chain_adc_host
  import chain_pkg::*;
#(
  parameter int CHAIN     = 3,
  parameter int WBITS     = 12,
  parameter int RC_LOW    = 3,
  parameter int DCLK_HALF = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   busy_i,
  input  logic                   sdata_i,
  output logic                   rc_o,
  output logic                   cs_n_o,
  output logic                   dclk_o,
  output logic [CHAIN*WBITS-1:0] words_o,
  output logic                   valid_o,
  output logic                   active_o
);
  localparam int TOTAL = CHAIN * WBITS;

  logic run, tick, last_bit;
  logic [TOTAL-1:0] bits;

  chain_seq #(.RC_LOW(RC_LOW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .last_bit(last_bit), .rc_o(rc_o), .cs_n_o(cs_n_o), .run_o(run),
    .active_o(active_o), .valid_o(valid_o)
  );

  chain_dclk #(.DCLK_HALF(DCLK_HALF)) u_dclk (
    .clk(clk), .rst_n(rst_n), .run(run), .dclk_o(dclk_o), .tick_o(tick)
  );

  chain_collect #(.TOTAL(TOTAL)) u_col (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .sdata(sdata_i),
    .last_o(last_bit), .bits_o(bits)
  );

  // first-received group sits highest in the shift register
  for (genvar k = 0; k < CHAIN; k++) begin : g_word
    assign words_o[k*WBITS +: WBITS] = bits[group_base(k, CHAIN, WBITS) +: WBITS];
  end

  assert_valid_idle_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cs_n_o && !dclk_o));
  assert_dclk_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !dclk_o);

endmodule

// File: tb/sim_chain_adc_host.sv
module conv_model #(
  parameter int W  = 12,
  parameter int CT = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rc,
  input  logic         dclk,
  input  logic         tag,
  input  logic [W-1:0] ain,
  output logic         busy,
  output logic         data
);
  logic p_cs, p_rc, p_dk;
  logic [W-1:0] res, sr;
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cs <= 1'b1; p_rc <= 1'b1; p_dk <= 1'b0;
      busy <= 1'b1; cnt <= 0; res <= '0; sr <= '0;
    end else begin
      p_cs <= cs_n; p_rc <= rc; p_dk <= dclk;
      if (!cs_n && p_rc && !rc && busy) begin
        busy <= 1'b0; cnt <= CT;
      end else if (!busy) begin
        if (cnt == 0) begin busy <= 1'b1; res <= ain; end
        else cnt <= cnt - 1;
      end
      if ((p_cs && !cs_n && rc) || (!cs_n && !p_rc && rc)) sr <= res;
      else if (p_dk && !dclk) sr <= {sr[W-2:0], tag};
    end
  end
  assign data = sr[W-1];
endmodule

module sim_chain_adc_host;
  localparam int N = 3, W = 12, RCL = 3, HALF = 2, TOT = N * W;
  localparam logic [TOT-1:0] VECS [0:3] = '{
    36'h800_FFF_000, 36'h001_5A5_A5A, 36'h7FF_000_FFF, 36'h789_456_123 };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  always #2.5 clk = ~clk;

  logic rc, cs_n, dclk, valid, active;
  logic [TOT-1:0] words;
  logic [N-1:0] busy_v;
  logic [N:0] chain;
  logic [W-1:0] ain [N];
  assign chain[N] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_dev
    conv_model #(.W(W), .CT(20)) m (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .dclk(dclk),
      .tag(chain[i+1]), .ain(ain[i]), .busy(busy_v[i]), .data(chain[i]));
  end

  chain_adc_host #(.CHAIN(N), .WBITS(W), .RC_LOW(RCL), .DCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_v[0]),
    .sdata_i(chain[0]), .rc_o(rc), .cs_n_o(cs_n), .dclk_o(dclk),
    .words_o(words), .valid_o(valid), .active_o(active));

  int nchk = 0, nfail = 0;
  bit done = 0;

  // port monitors
  int n_conv, rcw, rcw_last, n_rise, hw, n_valid;
  bit p_rc = 1, p_dk = 0, p_bz = 1, bz_bad, hw_bad, dk_cs_bad, rc_cs_bad;
  always @(negedge clk) begin
    if (!rc && p_rc) n_conv++;
    if (rc && !p_rc) begin rcw_last = rcw; rcw = 0; end
    else if (!rc) rcw++;
    if (!rc && cs_n) rc_cs_bad = 1;
    if (dclk && !p_dk) n_rise++;
    if (dclk) hw++;
    if (!dclk && p_dk) begin if (hw != HALF) hw_bad = 1; hw = 0; end
    if (dclk && cs_n) dk_cs_bad = 1;
    if (busy_v[0] && !p_bz && !(rc && cs_n)) bz_bad = 1;
    if (valid) n_valid++;
    p_rc = rc; p_dk = dclk; p_bz = busy_v[0];
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    n_conv = 0; rcw = 0; rcw_last = 0; n_rise = 0; hw = 0; n_valid = 0;
    bz_bad = 0; hw_bad = 0; dk_cs_bad = 0; rc_cs_bad = 0;
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 3000 && !valid; t++) @(negedge clk);
  endtask

  task automatic run_vec(input logic [TOT-1:0] v, input bit extra_start);
    for (int k = 0; k < N; k++) ain[k] = v[k*W +: W];
    clear_mon();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (extra_start) begin
      for (int t = 0; t < 500 && !dclk; t++) @(negedge clk);
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
    wait_valid();
    chk(valid, "R6 valid seen", valid, 1);
    chk(cs_n && !dclk, "R8 lines idle at valid", {cs_n, dclk}, 2'b10);
    for (int k = 0; k < N; k++)
      chk(words[k*W +: W] == v[k*W +: W], $sformatf("R5 word %0d", k),
          words[k*W +: W], v[k*W +: W]);
    repeat (6) @(negedge clk);
    chk(words == v, "R6 words held", words, v);
    chk(n_valid == 1, "R6 valid width", n_valid, 1);
    chk(n_rise == TOT, "R4 dclk edges", n_rise, TOT);
    chk(!hw_bad && !dk_cs_bad, "R4 dclk shape", {hw_bad, dk_cs_bad}, 0);
    chk(rcw_last == RCL && !rc_cs_bad, "R2 rc low width", rcw_last, RCL);
    chk(!bz_bad, "R3 rc/cs high at busy rise", bz_bad, 0);
    if (extra_start) begin
      repeat (30) @(negedge clk);
      chk(n_conv == 1, "R7 single conversion", n_conv, 1);
      chk(!active, "R7 back to idle", active, 0);
      chk(n_valid == 1, "R7 single valid", n_valid, 1);
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) ain[k] = '0;
    repeat (3) @(negedge clk);
    chk(rc && cs_n && !dclk && !valid && !active, "R1 in reset",
        {rc, cs_n, dclk, valid, active}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rc && cs_n && !dclk && !valid && !active, "R1 after reset",
        {rc, cs_n, dclk, valid, active}, 5'b11000);
    for (int i = 0; i < 4; i++) run_vec(VECS[i], 1'b0);
    run_vec(36'h0F0_3C3_E1E, 1'b1);  // R7 start during readout
    run_vec(36'hFFF_FFF_FFF, 1'b0);  // R5 all ones, trailing tag zero
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule